// File: doc/BRIEF.md
# Shared-Subexpression Constant Multiplier

This block multiplies one unsigned operand by three fixed constants, 7, 106 and 210, and presents all three products at once. It does not use a separate multiplier for each constant. A single graph of three adder/subtractor nodes computes the partial products, and one node feeds more than one output. Constant bits that are zero produce no logic. Only the non-zero terms cost an adder.

The graph has three nodes and one free wire shift:

- 7·x is formed as 8·x − x.
- 105·x is formed as 16·(7·x) − 7·x.
- 106·x is 105·x + x.
- 210·x is 105·x moved one bit to the left, so it needs no extra node.

A parameter chooses whether the products leave combinationally or through one register stage. A valid flag travels with the data in both cases. Each output is sized so that no input value can overflow it.

Top module: `cmul_const_trio`

## Requirements
- R1: `prod7` equals 7·x as an unsigned value of W+3 bits for every x.
- R2: `prod106` equals 106·x as an unsigned value of W+7 bits for every x.
- R3: `prod210` equals 210·x as an unsigned value of W+8 bits for every x. At the largest x, none of the three outputs wraps.
- R4: `prod210` is always even (bit 0 is zero) and equals 2·`prod106` − 2·x.
- R5: With OUT_REG = 0, the products follow x in the same cycle and `out_valid` equals `in_valid` combinationally.
- R6: With OUT_REG = 1, a value presented with `in_valid` high appears on the product outputs one rising edge later, with `out_valid` high.
- R7: With OUT_REG = 1, while `rst` is high at a rising edge, `out_valid` and all three products become zero.
- R8: With OUT_REG = 1, an edge where `in_valid` is low drives `out_valid` low and leaves all three products at their previous values, whatever x is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks x as a value to be multiplied |
| x | input | W | Unsigned operand |
| out_valid | output | 1 | Marks the product outputs as valid |
| prod7 | output | W+3 | 7·x |
| prod106 | output | W+7 | 106·x |
| prod210 | output | W+8 | 210·x |

## Verification
Every operand value is applied, in both the combinational and the registered variant. This exhaustive sweep catches an edge that is shifted the wrong way, an add swapped for a subtract, or a wrong node reused for an output, because any of these gives a wrong product for some x. The all-ones operand targets a truncated output width: an output one bit too narrow would wrap only at the top of the range. Zero and the parity relation of 210·x catch a missing one-bit shift. A capture with the valid flag low checks that an enable ignored by the register shows up as products that change. The reset check catches a valid flag or a product register that does not clear.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    // Constant set handled by the graph
    localparam int unsigned K_LO  = 7;
    localparam int unsigned K_MID = 106;
    localparam int unsigned K_HI  = 210;

    // Node operation selector
    typedef enum logic {
        NODE_ADD = 1'b0,
        NODE_SUB = 1'b1
    } node_op_e;

    // Bits needed to hold w-bit operand times constant k
    function automatic int prod_width(input int w, input int unsigned k);
        return w + $clog2(k + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cmul_node.sv
module cmul_node
    import cmul_pkg::*;
#(
    parameter int       A_W   = 8,
    parameter int       B_W   = 8,
    parameter int       OUT_W = 12,
    parameter int       SHIFT = 0,
    parameter node_op_e OP    = NODE_ADD
) (
    input  logic [A_W-1:0]   a,
    input  logic [B_W-1:0]   b,
    output logic [OUT_W-1:0] y
);

    localparam int EXT_W = max2(A_W + SHIFT, B_W) + 1;

    logic [EXT_W-1:0] a_ext;
    logic [EXT_W-1:0] b_ext;
    logic [EXT_W-1:0] y_full;

    assign a_ext = EXT_W'(a) << SHIFT;
    assign b_ext = EXT_W'(b);

    generate
        if (OP == NODE_SUB) begin : g_sub
            assign y_full = a_ext - b_ext;
        end else begin : g_add
            assign y_full = a_ext + b_ext;
        end
    endgenerate

    assign y = y_full[OUT_W-1:0];

    // R3: the node result fits its declared width (no hidden wrap)
    always_comb begin
        if (!$isunknown(y_full)) begin
            a_r3_node_fits: assert ((y_full >> OUT_W) == '0)
                else $error("node result exceeds output width");
        end
    end

    // R1: a subtracting node never goes negative
    generate
        if (OP == NODE_SUB) begin : g_sub_chk
            always_comb begin
                if (!$isunknown(a_ext) && !$isunknown(b_ext)) begin
                    a_r1_sub_nonneg: assert (a_ext >= b_ext)
                        else $error("subtracting node underflows");
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cmul_graph.sv
module cmul_graph
    import cmul_pkg::*;
#(
    parameter int W = 10
) (
    input  logic [W-1:0]                     x,
    output logic [prod_width(W, K_LO)-1:0]   p_lo,
    output logic [prod_width(W, K_MID)-1:0]  p_mid,
    output logic [prod_width(W, K_HI)-1:0]   p_hi
);

    localparam int LO_W  = prod_width(W, K_LO);
    localparam int MID_W = prod_width(W, K_MID);
    localparam int HI_W  = prod_width(W, K_HI);
    localparam int N105_W = MID_W;   // 105 < 128

    logic [LO_W-1:0]   n7;
    logic [N105_W-1:0] n105;

    // node 1: 8x - x
    cmul_node #(
        .A_W(W), .B_W(W), .OUT_W(LO_W), .SHIFT(3), .OP(NODE_SUB)
    ) u_n7 (
        .a(x), .b(x), .y(n7)
    );

    // node 2: 16*(7x) - 7x
    cmul_node #(
        .A_W(LO_W), .B_W(LO_W), .OUT_W(N105_W), .SHIFT(4), .OP(NODE_SUB)
    ) u_n105 (
        .a(n7), .b(n7), .y(n105)
    );

    // node 3: 105x + x
    cmul_node #(
        .A_W(N105_W), .B_W(W), .OUT_W(MID_W), .SHIFT(0), .OP(NODE_ADD)
    ) u_n106 (
        .a(n105), .b(x), .y(p_mid)
    );

    assign p_lo = n7;
    assign p_hi = {n105, 1'b0};   // 210x as a free wire shift

    // R2: middle product is 15 times the low product plus x (shared node reuse)
    always_comb begin
        if (!$isunknown(x)) begin
            a_r2_reuse: assert (HI_W'(p_mid) == HI_W'(15) * HI_W'(p_lo) + HI_W'(x))
                else $error("106x not consistent with 7x");
            a_r4_hi_even: assert (HI_W'(p_hi) + HI_W'(2) * HI_W'(x) == HI_W'(2) * HI_W'(p_mid))
                else $error("210x not consistent with 106x");
        end
    end

endmodule

// File: rtl/cmul_out_stage.sv
module cmul_out_stage #(
    parameter int DATA_W   = 32,
    parameter bit REGISTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] d,
    output logic              out_valid,
    output logic [DATA_W-1:0] q
);

    generate
        if (REGISTER) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_valid <= 1'b0;
                    q         <= '0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) begin
                        q <= d;
                    end
                end
            end

            // R6: captured data appears one edge later with valid set
            a_r6_capture: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> (out_valid && q == $past(d)))
                else $error("registered capture wrong");

            // R8: no capture when valid is low
            a_r8_hold: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> (!out_valid && $stable(q)))
                else $error("register changed without valid");

            // R7: reset clears the stage
            a_r7_reset_clear: assert property (@(posedge clk)
                rst |=> (!out_valid && q == '0))
                else $error("reset did not clear output stage");
        end else begin : g_bypass
            assign out_valid = in_valid;
            assign q         = d;
        end
    endgenerate

endmodule

// File: rtl/cmul_const_trio.sv
module cmul_const_trio
    import cmul_pkg::*;
#(
    parameter int W       = 10,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_valid,
    input  logic [W-1:0]                     x,
    output logic                             out_valid,
    output logic [prod_width(W, K_LO)-1:0]   prod7,
    output logic [prod_width(W, K_MID)-1:0]  prod106,
    output logic [prod_width(W, K_HI)-1:0]   prod210
);

    localparam int LO_W  = prod_width(W, K_LO);
    localparam int MID_W = prod_width(W, K_MID);
    localparam int HI_W  = prod_width(W, K_HI);
    localparam int ALL_W = LO_W + MID_W + HI_W;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [MID_W-1:0] mid;
        logic [LO_W-1:0]  lo;
    } prod_set_t;

    prod_set_t raw;
    prod_set_t held;

    cmul_graph #(.W(W)) u_graph (
        .x     (x),
        .p_lo  (raw.lo),
        .p_mid (raw.mid),
        .p_hi  (raw.hi)
    );

    cmul_out_stage #(.DATA_W(ALL_W), .REGISTER(OUT_REG)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .d         (raw),
        .out_valid (out_valid),
        .q         (held)
    );

    assign prod7   = held.lo;
    assign prod106 = held.mid;
    assign prod210 = held.hi;

endmodule

// File: tb/test_cmul_const_trio.sv
module test_cmul_const_trio;

    localparam int W     = 10;
    localparam int LO_W  = W + 3;
    localparam int MID_W = W + 7;
    localparam int HI_W  = W + 8;
    localparam longint XMAX = (64'd1 << W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [W-1:0] x = '0;

    logic             r_valid, c_valid;
    logic [LO_W-1:0]  r_p7,   c_p7;
    logic [MID_W-1:0] r_p106, c_p106;
    logic [HI_W-1:0]  r_p210, c_p210;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cmul_const_trio #(.W(W), .OUT_REG(1'b1)) i_cmul_const_trio (
        .clk(clk), .rst(rst), .in_valid(in_valid), .x(x),
        .out_valid(r_valid), .prod7(r_p7), .prod106(r_p106), .prod210(r_p210)
    );

    cmul_const_trio #(.W(W), .OUT_REG(1'b0)) i_cmul_const_trio_comb (
        .clk(clk), .rst(rst), .in_valid(in_valid), .x(x),
        .out_valid(c_valid), .prod7(c_p7), .prod106(c_p106), .prod210(c_p210)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R7: reset state of the registered variant
    task automatic t_reset();
        in_valid = 1'b1;
        x = W'(XMAX);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(r_valid == 1'b0, "R7 valid", longint'(r_valid), 0);
        chk(r_p7 == '0, "R7 prod7", longint'(r_p7), 0);
        chk(r_p106 == '0, "R7 prod106", longint'(r_p106), 0);
        chk(r_p210 == '0, "R7 prod210", longint'(r_p210), 0);
        rst = 1'b0;
        in_valid = 1'b0;
    endtask

    // R1 R2 R3 R5: exhaustive combinational sweep
    task automatic t_sweep_comb();
        for (longint v = 0; v <= XMAX; v++) begin
            @(negedge clk);
            x = W'(v);
            in_valid = v[0];
            #1;
            chk(longint'(c_p7) == v * 7, "R1 comb", longint'(c_p7), v * 7);
            chk(longint'(c_p106) == v * 106, "R2 comb", longint'(c_p106), v * 106);
            chk(longint'(c_p210) == v * 210, "R3 comb", longint'(c_p210), v * 210);
            chk(c_valid == v[0], "R5 valid", longint'(c_valid), longint'(v[0]));
        end
    endtask

    // R6: exhaustive registered sweep, one edge of latency
    task automatic t_sweep_reg();
        for (longint v = 0; v <= XMAX; v++) begin
            @(negedge clk);
            x = W'(v);
            in_valid = 1'b1;
            @(posedge clk);
            #1;
            x = W'(XMAX - v);   // disturb input after capture
            #1;
            chk(r_valid == 1'b1, "R6 valid", longint'(r_valid), 1);
            chk(longint'(r_p7) == v * 7, "R6 prod7", longint'(r_p7), v * 7);
            chk(longint'(r_p106) == v * 106, "R6 prod106", longint'(r_p106), v * 106);
            chk(longint'(r_p210) == v * 210, "R6 prod210", longint'(r_p210), v * 210);
        end
    endtask

    // R8: valid low leaves products unchanged
    task automatic t_hold();
        @(negedge clk);
        x = 10'd37;
        in_valid = 1'b1;
        @(negedge clk);
        x = 10'd900;
        in_valid = 1'b0;
        @(negedge clk);
        chk(r_valid == 1'b0, "R8 valid low", longint'(r_valid), 0);
        chk(longint'(r_p7) == 37 * 7, "R8 prod7 held", longint'(r_p7), 37 * 7);
        chk(longint'(r_p106) == 37 * 106, "R8 prod106 held", longint'(r_p106), 37 * 106);
        chk(longint'(r_p210) == 37 * 210, "R8 prod210 held", longint'(r_p210), 37 * 210);
    endtask

    // R3 R4: boundaries and parity relation
    task automatic t_edges();
        longint pts [4] = '{0, 1, XMAX - 1, XMAX};
        foreach (pts[i]) begin
            @(negedge clk);
            x = W'(pts[i]);
            in_valid = 1'b1;
            #1;
            chk(c_p210[0] == 1'b0, "R4 even", longint'(c_p210[0]), 0);
            chk(longint'(c_p210) == 2 * longint'(c_p106) - 2 * pts[i], "R4 relation",
                longint'(c_p210), 2 * longint'(c_p106) - 2 * pts[i]);
            chk(longint'(c_p210) == pts[i] * 210, "R3 edge", longint'(c_p210), pts[i] * 210);
            chk(longint'(c_p106) == pts[i] * 106, "R2 edge", longint'(c_p106), pts[i] * 106);
            chk(longint'(c_p7) == pts[i] * 7, "R1 edge", longint'(c_p7), pts[i] * 7);
        end
    endtask

    initial begin
        t_reset();
        t_sweep_comb();
        t_sweep_reg();
        t_hold();
        t_edges();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule